// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer for 36-bit words with a power-of-two depth set by a parameter. Besides the usual "can read" and "can write" indications it raises two warning flags: one when the buffer is nearly drained, one when it is nearly full. Each warning has its own threshold. A threshold can come from a small table of presets chosen at master reset. It can also be loaded later, one bit at a time on a serial pin or all at once from the write-data bus.

A mode input, sampled at master reset, selects one of two output timings. In standard timing a word leaves the buffer only on a read, and the read flag means "not empty". In fall-through timing the oldest word is moved into the output register without a read, and the read flag means "a valid word is on the output". That register adds one extra word of capacity.

There are two resets. Master reset clears the contents and reloads the configuration. Partial reset clears the contents but keeps the mode and the thresholds. A mark input records the current head of the queue, and a retransmit input rewinds reading to that point so the same words can be read again.

Top module: `pflag_fifo`

## Requirements
- R1: While `mrst_i` is high at a clock edge, the buffer empties, `rd_data_o` becomes zero, the mode is taken from `fwft_sel_i` (0 = standard, 1 = fall-through), and both thresholds load the preset picked by `preset_sel_i`. The encodings are 0→8, 1→16, 2→64, 3→256, 4→1024, and 5 to 7→8. Every preset is clamped to DEPTH−1. After the edge `rd_flag_o`=0, `wr_flag_o`=1 and `almost_empty_o`=1.
- R2: Words leave in the order they were written. In standard mode a read (`rd_en_i` high with `rd_flag_o` high) places the oldest word on `rd_data_o` after that edge. `rd_flag_o` is 1 exactly when the memory holds at least one word.
- R3: `wr_flag_o` is 0 exactly when the memory holds DEPTH words. A write offered while it is 0 is dropped and leaves contents and flags unchanged.
- R4: In standard mode a read while `rd_flag_o` is 0 has no effect, and `rd_data_o` keeps its value.
- R5: In fall-through mode a word written at edge k appears on `rd_data_o` with `rd_flag_o`=1 after edge k+1, without any read, when nothing older is waiting. `rd_en_i` with `rd_flag_o` high consumes it. Total capacity is DEPTH+1 words.
- R6: `almost_empty_o` is 1 when the stored word count (in fall-through mode including a valid output word) is less than or equal to the empty threshold.
- R7: `almost_full_o` is 1 when the free memory space, DEPTH minus the words held in memory (excluding a fall-through output word), is less than or equal to the full threshold.
- R8: With `par_ld_i` high, the empty threshold loads from `wr_data_i[AW-1:0]` and the full threshold from `wr_data_i[18+AW-1:18]`, where AW = log2(DEPTH). No word is written that cycle, and this load takes priority over the serial load.
- R9: With `ser_en_i` high (and `par_ld_i` low), the 2·AW-bit pair {full threshold, empty threshold} shifts left by one and `ser_din_i` enters bit 0. The first bit sent ends up as the full threshold's MSB.
- R10: Partial reset (`prst_i`) empties the buffer, clears the output word and resets the mark, but keeps the mode and both thresholds.
- R11: A read and a write on the same edge both take effect, and the word count is unchanged.
- R12: `mark_i` records the oldest unconsumed word as the retransmit point; a master or partial reset sets it to the next word written. `rt_i` with `wr_en_i` low moves reading back to that point. In fall-through mode the output word is dropped and refilled on the next edge. Retransmit is only defined when at most DEPTH words have been written since the mark.
- R13: `rt_i` is ignored while `wr_en_i` is high: the write, read and mark of that cycle proceed as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| fwft_sel_i | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| preset_sel_i | input | 3 | Threshold preset sampled at master reset |
| ser_en_i | input | 1 | Serial threshold shift enable |
| ser_din_i | input | 1 | Serial threshold data bit |
| par_ld_i | input | 1 | Parallel threshold load from the write-data bus |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 36 | Write word, also parallel threshold source |
| rd_en_i | input | 1 | Read request |
| mark_i | input | 1 | Record the retransmit point |
| rt_i | input | 1 | Rewind reading to the retransmit point |
| rd_data_o | output | 36 | Read word |
| rd_flag_o | output | 1 | Standard: not empty; fall-through: output word valid |
| wr_flag_o | output | 1 | Memory has free space |
| almost_empty_o | output | 1 | Word count at or below the empty threshold |
| almost_full_o | output | 1 | Free space at or below the full threshold |

## Verification
The bench builds the block with DEPTH=16, so the thresholds are 4 bits wide and a full fill-and-drain takes a few dozen cycles. This small depth makes the bench's sweeps exhaustive. It fills the buffer to overflow in both timing modes and walks every occupancy level under all eight preset encodings. It also reaches the clamping of the 64, 256 and 1024 presets to 15. Keeping the write count since a mark within 16 words puts retransmit and the wrap of the memory pointers in range of short sequences.

// File: rtl/pflag_fifo_pkg.sv
`timescale 1ns/1ps
package pflag_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Preset threshold table, clamped so a threshold never reaches the depth.
    function automatic int preset_offset(input logic [2:0] sel, input int depth);
        int v;
        case (sel)
            3'd1:    v = 16;
            3'd2:    v = 64;
            3'd3:    v = 256;
            3'd4:    v = 1024;
            default: v = 8;
        endcase
        if (v > depth - 1) v = depth - 1;
        return v;
    endfunction

endpackage

// File: rtl/pflag_fifo_mem.sv
`timescale 1ns/1ps
module pflag_fifo_mem #(
    parameter int DATA_W = 36,
    parameter int AW     = 11
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int ENTRIES = 1 << AW;

    logic [DATA_W-1:0] store_q [ENTRIES];

    always_ff @(posedge clk_i) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = store_q[raddr_i];

endmodule

// File: rtl/pflag_fifo_cfg.sv
`timescale 1ns/1ps
module pflag_fifo_cfg
    import pflag_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk_i,
    input  logic          mrst_i,
    input  logic          fwft_sel_i,
    input  logic [2:0]    preset_sel_i,
    input  logic          ser_en_i,
    input  logic          ser_din_i,
    input  logic          par_ld_i,
    input  logic [AW-1:0] par_ae_i,
    input  logic [AW-1:0] par_af_i,
    output fifo_mode_e    mode_o,
    output logic [AW-1:0] ae_off_o,
    output logic [AW-1:0] af_off_o
);
    typedef struct packed {
        fifo_mode_e    mode;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        logic [2*AW-1:0] chain;
        cfg_d = cfg_q;
        chain = {cfg_q.af, cfg_q.ae};
        if (mrst_i) begin
            cfg_d.mode = fwft_sel_i ? MODE_FWFT : MODE_STD;
            cfg_d.ae   = AW'(preset_offset(preset_sel_i, DEPTH));
            cfg_d.af   = AW'(preset_offset(preset_sel_i, DEPTH));
        end else if (par_ld_i) begin
            cfg_d.ae = par_ae_i;
            cfg_d.af = par_af_i;
        end else if (ser_en_i) begin
            chain    = {chain[2*AW-2:0], ser_din_i};
            cfg_d.af = chain[2*AW-1:AW];
            cfg_d.ae = chain[AW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign mode_o   = cfg_q.mode;
    assign ae_off_o = cfg_q.ae;
    assign af_off_o = cfg_q.af;

    // R10: configuration only moves on master reset or an explicit load.
    assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (mrst_i)
        (!ser_en_i && !par_ld_i) |=> ($stable(ae_off_o) && $stable(af_off_o)));

    // R1: the timing mode is frozen between master resets.
    assert_mode_frozen_R1: assert property (@(posedge clk_i) disable iff (mrst_i)
        !$past(mrst_i) |-> $stable(mode_o));

endmodule

// File: rtl/pflag_fifo_flags.sv
`timescale 1ns/1ps
module pflag_fifo_flags
    import pflag_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  fifo_mode_e    mode_i,
    input  logic [AW:0]   used_i,
    input  logic          ov_i,
    input  logic [AW-1:0] ae_off_i,
    input  logic [AW-1:0] af_off_i,
    output logic          rd_flag_o,
    output logic          wr_flag_o,
    output logic          almost_empty_o,
    output logic          almost_full_o
);
    localparam int PW = AW + 1;

    logic [PW:0]   level;
    logic [PW-1:0] space;

    always_comb begin
        level          = {1'b0, used_i} + (PW+1)'(ov_i);
        space          = PW'(DEPTH) - used_i;
        rd_flag_o      = (mode_i == MODE_FWFT) ? ov_i : (used_i != '0);
        wr_flag_o      = (used_i != PW'(DEPTH));
        almost_empty_o = (level <= (PW+1)'(ae_off_i));
        almost_full_o  = (space <= PW'(af_off_i));
    end

endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 2048
) (
    input  logic              clk_i,
    input  logic              mrst_i,
    input  logic              prst_i,
    input  logic              fwft_sel_i,
    input  logic [2:0]        preset_sel_i,
    input  logic              ser_en_i,
    input  logic              ser_din_i,
    input  logic              par_ld_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              mark_i,
    input  logic              rt_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_flag_o,
    output logic              wr_flag_o,
    output logic              almost_empty_o,
    output logic              almost_full_o
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic [PW-1:0]     wr_ptr;
        logic [PW-1:0]     rd_ptr;
        logic [PW-1:0]     mark;
        logic              ov;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    fifo_mode_e        mode_q;
    logic [AW-1:0]     ae_off_q, af_off_q;
    logic [PW-1:0]     used_q;
    logic [DATA_W-1:0] mem_word;
    logic              mem_we;

    pflag_fifo_cfg #(.DEPTH(DEPTH), .AW(AW)) u_cfg (
        .clk_i        (clk_i),
        .mrst_i       (mrst_i),
        .fwft_sel_i   (fwft_sel_i),
        .preset_sel_i (preset_sel_i),
        .ser_en_i     (ser_en_i),
        .ser_din_i    (ser_din_i),
        .par_ld_i     (par_ld_i),
        .par_ae_i     (wr_data_i[AW-1:0]),
        .par_af_i     (wr_data_i[HALF +: AW]),
        .mode_o       (mode_q),
        .ae_off_o     (ae_off_q),
        .af_off_o     (af_off_q)
    );

    pflag_fifo_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .waddr_i (ctl_q.wr_ptr[AW-1:0]),
        .wdata_i (wr_data_i),
        .raddr_i (ctl_q.rd_ptr[AW-1:0]),
        .rdata_o (mem_word)
    );

    assign used_q = ctl_q.wr_ptr - ctl_q.rd_ptr;

    always_comb begin
        logic [PW-1:0] head;
        logic          consume;
        ctl_d   = ctl_q;
        mem_we  = 1'b0;
        consume = 1'b0;
        head    = (mode_q == MODE_FWFT && ctl_q.ov) ? ctl_q.rd_ptr - 1'b1 : ctl_q.rd_ptr;
        if (prst_i) begin
            ctl_d = '0;
        end else if (rt_i && !wr_en_i) begin
            ctl_d.rd_ptr = ctl_q.mark;
            ctl_d.ov     = 1'b0;
        end else begin
            if (mark_i) ctl_d.mark = head;
            if (mode_q == MODE_STD) begin
                if (rd_en_i && used_q != '0) begin
                    ctl_d.dout   = mem_word;
                    ctl_d.rd_ptr = ctl_q.rd_ptr + 1'b1;
                end
            end else begin
                consume = rd_en_i && ctl_q.ov;
                if (used_q != '0 && (!ctl_q.ov || consume)) begin
                    ctl_d.dout   = mem_word;
                    ctl_d.rd_ptr = ctl_q.rd_ptr + 1'b1;
                    ctl_d.ov     = 1'b1;
                end else if (consume) begin
                    ctl_d.ov = 1'b0;
                end
            end
            if (wr_en_i && !par_ld_i && used_q != PW'(DEPTH)) begin
                mem_we       = 1'b1;
                ctl_d.wr_ptr = ctl_q.wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (mrst_i) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pflag_fifo_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
        .mode_i         (mode_q),
        .used_i         (used_q),
        .ov_i           (ctl_q.ov),
        .ae_off_i       (ae_off_q),
        .af_off_i       (af_off_q),
        .rd_flag_o      (rd_flag_o),
        .wr_flag_o      (wr_flag_o),
        .almost_empty_o (almost_empty_o),
        .almost_full_o  (almost_full_o)
    );

    assign rd_data_o = ctl_q.dout;

    // R3: memory occupancy never exceeds the depth.
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (mrst_i)
        used_q <= PW'(DEPTH));

    // R3: a full buffer stays full until something leaves it.
    assert_full_stays_R3: assert property (@(posedge clk_i) disable iff (mrst_i)
        (!wr_flag_o && rd_flag_o && !rd_en_i && !rt_i && !prst_i) |=> !wr_flag_o);

    // R4: a read of an empty buffer in standard mode leaves the output alone.
    assert_empty_read_hold_R4: assert property (@(posedge clk_i) disable iff (mrst_i)
        (mode_q == MODE_STD && !rd_flag_o && !prst_i) |=> $stable(rd_data_o));

    // R5: a valid fall-through word waits until it is consumed.
    assert_fwft_hold_R5: assert property (@(posedge clk_i) disable iff (mrst_i)
        (mode_q == MODE_FWFT && rd_flag_o && !rd_en_i && !rt_i && !prst_i)
        |=> (rd_flag_o && $stable(rd_data_o)));

    // R10: partial reset leaves an empty buffer behind.
    assert_prst_clears_R10: assert property (@(posedge clk_i) disable iff (mrst_i)
        prst_i |=> (!rd_flag_o && wr_flag_o && almost_empty_o));

    // R11: a matched read and write in standard mode keep the count.
    assert_simul_level_R11: assert property (@(posedge clk_i) disable iff (mrst_i)
        (mode_q == MODE_STD && rd_en_i && wr_en_i && rd_flag_o && wr_flag_o
         && !par_ld_i && !prst_i) |=> $stable(used_q));

endmodule

// File: tb/pflag_fifo_test.sv
`timescale 1ns/1ps
module pflag_fifo_test;
    localparam int DW    = 36;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          mrst, prst, fwft_sel, ser_en, ser_din, par_ld;
    logic [2:0]    preset_sel;
    logic          wr_en, rd_en, mark, rt;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_flag, wr_flag, almost_empty, almost_full;

    always #2.5 clk = ~clk;

    pflag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk_i(clk), .mrst_i(mrst), .prst_i(prst), .fwft_sel_i(fwft_sel),
        .preset_sel_i(preset_sel), .ser_en_i(ser_en), .ser_din_i(ser_din),
        .par_ld_i(par_ld), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .mark_i(mark), .rt_i(rt), .rd_data_o(rd_data), .rd_flag_o(rd_flag),
        .wr_flag_o(wr_flag), .almost_empty_o(almost_empty), .almost_full_o(almost_full)
    );

    int checks = 0;
    int fails  = 0;
    int seq    = 0;

    // reference model state
    logic [DW-1:0] hist [0:255];
    int            wi, ri, mi;
    bit            ov_m, fw_m;
    logic [DW-1:0] dout_m;
    int            ae_m, af_m;

    function automatic logic [DW-1:0] word(input int n);
        return {4'hA, 32'(n * 32'd2654435761 + 32'd17)};
    endfunction

    function automatic int preset(input int sel);
        int v;
        v = (sel == 1) ? 16 : (sel == 2) ? 64 : (sel == 3) ? 256 : (sel == 4) ? 1024 : 8;
        return (v > DEPTH - 1) ? DEPTH - 1 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int  used, level;
        bit  e_rd, e_wr, e_ae, e_af;
        used  = wi - ri;
        level = used + int'(ov_m);
        e_rd  = fw_m ? ov_m : (used > 0);
        e_wr  = (used < DEPTH);
        e_ae  = (level <= ae_m);
        e_af  = ((DEPTH - used) <= af_m);
        chk(rd_flag == e_rd, tag, "rd_flag", 64'(rd_flag), 64'(e_rd));
        chk(wr_flag == e_wr, tag, "wr_flag", 64'(wr_flag), 64'(e_wr));
        chk(almost_empty == e_ae, tag, "almost_empty", 64'(almost_empty), 64'(e_ae));
        chk(almost_full == e_af, tag, "almost_full", 64'(almost_full), 64'(e_af));
        chk(rd_data === dout_m, tag, "rd_data", 64'(rd_data), 64'(dout_m));
    endtask

    task automatic step(input bit wen, input logic [DW-1:0] wd, input bit ren,
                        input bit rtx, input bit mk, input bit pl, input bit se,
                        input bit sd, input bit pr, input string tag);
        int used;
        bit consume, fetch;
        logic [2*AW-1:0] chain;
        wr_en = wen; wr_data = wd; rd_en = ren; rt = rtx; mark = mk;
        par_ld = pl; ser_en = se; ser_din = sd; prst = pr;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; rt = 0; mark = 0; par_ld = 0; ser_en = 0; prst = 0;
        used = wi - ri;
        if (pr) begin
            wi = 0; ri = 0; mi = 0; ov_m = 0; dout_m = '0;
        end else if (rtx && !wen) begin
            ri = mi; ov_m = 0;
        end else begin
            if (mk) mi = (fw_m && ov_m) ? ri - 1 : ri;
            if (!fw_m) begin
                if (ren && used > 0) begin dout_m = hist[ri]; ri++; end
            end else begin
                consume = ren && ov_m;
                fetch   = (used > 0) && (!ov_m || consume);
                if (fetch) begin dout_m = hist[ri]; ri++; ov_m = 1; end
                else if (consume) ov_m = 0;
            end
            if (wen && !pl && used < DEPTH) begin hist[wi] = wd; wi++; end
        end
        if (pl) begin
            ae_m = int'(wd[AW-1:0]);
            af_m = int'(wd[18 +: AW]);
        end else if (se) begin
            chain = {AW'(af_m), AW'(ae_m)};
            chain = {chain[2*AW-2:0], sd};
            af_m  = int'(chain[2*AW-1:AW]);
            ae_m  = int'(chain[AW-1:0]);
        end
        check_all(tag);
    endtask

    task automatic put(input string tag);
        step(1, word(seq), 0, 0, 0, 0, 0, 0, 0, tag);
        seq++;
    endtask

    task automatic get(input string tag);
        step(0, '0, 1, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_mrst(input bit fw, input int sel);
        mrst = 1; fwft_sel = fw; preset_sel = 3'(sel);
        @(posedge clk);
        #1;
        mrst = 0;
        wi = 0; ri = 0; mi = 0; ov_m = 0; dout_m = '0; fw_m = fw;
        ae_m = preset(sel); af_m = preset(sel);
        check_all("R1");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [7:0]    bits;
        mrst = 1; prst = 0; fwft_sel = 0; preset_sel = 0; ser_en = 0; ser_din = 0;
        par_ld = 0; wr_en = 0; wr_data = '0; rd_en = 0; mark = 0; rt = 0;
        repeat (3) @(posedge clk);
        #1;
        do_mrst(0, 0);

        // standard mode: fill past full, drain past empty
        for (int i = 0; i < DEPTH + 1; i++) put("R3");
        for (int i = 0; i < DEPTH; i++) get("R2");
        get("R4");
        get("R4");

        // simultaneous read and write
        for (int i = 0; i < 5; i++) put("R11");
        for (int i = 0; i < 6; i++) begin
            step(1, word(seq), 1, 0, 0, 0, 0, 0, 0, "R11");
            seq++;
        end
        for (int i = 0; i < 6; i++) get("R11");

        // every preset encoding, walked across every level
        for (int s = 0; s < 8; s++) begin
            do_mrst(0, s);
            for (int i = 0; i < DEPTH + 1; i++) put("R6 R7");
        end

        // parallel threshold load; the write on that cycle is dropped
        do_mrst(0, 0);
        v = '0; v[3:0] = 4'd3; v[21:18] = 4'd5;
        step(1, v, 0, 0, 0, 1, 1, 1, 0, "R8");
        for (int i = 0; i < DEPTH; i++) put("R8");
        step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R10");

        // serial threshold load: full=6, empty=2, sent MSB first
        bits = 8'b0110_0010;
        for (int b = 7; b >= 0; b--) step(0, '0, 0, 0, 0, 0, 1, bits[b], 0, "R9");
        for (int i = 0; i < 10; i++) put("R9");
        step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < DEPTH; i++) put("R10");

        // retransmit in standard mode
        do_mrst(0, 1);
        for (int i = 0; i < 6; i++) put("R12");
        for (int i = 0; i < 3; i++) get("R12");
        step(0, '0, 0, 1, 0, 0, 0, 0, 0, "R12");
        for (int i = 0; i < 2; i++) get("R12");
        step(0, '0, 0, 0, 1, 0, 0, 0, 0, "R12");
        get("R12");
        step(0, '0, 0, 1, 0, 0, 0, 0, 0, "R12");
        get("R12");
        step(1, word(seq), 0, 1, 0, 0, 0, 0, 0, "R13");
        seq++;
        for (int i = 0; i < 6; i++) get("R13");

        // fall-through mode
        do_mrst(1, 0);
        put("R5");
        idle("R5");
        for (int i = 0; i < DEPTH + 1; i++) put("R5");
        for (int i = 0; i < DEPTH + 2; i++) get("R5");
        for (int i = 0; i < 3; i++) begin
            step(1, word(seq), 1, 0, 0, 0, 0, 0, 0, "R11");
            seq++;
        end
        step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R10");
        put("R10");
        idle("R10");

        // fall-through retransmit, mark taken while a word sits on the output
        step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R12");
        for (int i = 0; i < 5; i++) put("R12");
        get("R12");
        step(0, '0, 0, 0, 1, 0, 0, 0, 0, "R12");
        get("R12");
        get("R12");
        step(0, '0, 0, 1, 0, 0, 0, 0, 0, "R12");
        idle("R12");
        for (int i = 0; i < 5; i++) get("R12");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule